// File: doc/BRIEF.md
# Exclusive-Access Monitor with Paired Conditional Store

This block combines a local exclusive-access monitor with an execution unit for a conditional store of two register operands. A load-exclusive request arms the monitor. It records a base address and a power-of-two byte span. A later paired store request supplies a base address, two element operands, an element size (half of the operand width or the full operand width) and a byte-order flag.

The unit checks whether the armed span covers every byte the pair would touch. If it does, and the base is suitably aligned, the unit issues one combined memory write that carries both elements, and it reports success. In every other case it writes nothing and reports failure. Any paired store returns the monitor to the open state, whatever its outcome.

The response and the write request are registered, one cycle after the request is accepted. A ready output holds off new paired stores while a memory write waits for the memory to acknowledge it.

Top module: `excl_pair_store`

## Requirements
- R1: After reset, ready is 1, resp_valid, align_fault and mem_we are 0, and the monitor is open, so a paired store fails.
- R2: A paired store accepted at a clock edge (st_valid=1 while ready=1) produces resp_valid=1 for exactly the following cycle. Without an accepted store, resp_valid is 0.
- R3: The check passes only if the monitor is armed and the span [mon_addr, mon_addr + 2^ldx_log2 - 1] contains every byte from st_addr to st_addr + total - 1. The total is 8 bytes when st_wide=0 and 16 bytes when st_wide=1.
- R4: On a pass, mem_we=1 with mem_addr=st_addr and mem_wide=st_wide. In mem_wdata, the second element (st_elem_b) is in the high half when st_big_endian=0, and the first element (st_elem_a) is in the high half when st_big_endian=1. With st_wide=0, only the low 32 bits of each element are used, they fill mem_wdata[63:0], and mem_wdata[127:64] is 0.
- R5: resp_status is 32'd0 when the write was issued and 32'd1 when it was not. Bits 31:1 are always 0.
- R6: An accepted paired store clears the monitor, so a second paired store without a new load-exclusive fails.
- R7: A failed paired store never raises mem_we.
- R8: If st_addr is not aligned to the total size, the store fails, align_fault=1 in the response cycle, and nothing is written. If st_base_is_sp=1, st_addr must also be 16-byte aligned, otherwise the same fault is raised.
- R9: A clear request (clr_valid=1) returns the monitor to open, so a following paired store fails.
- R10: While mem_we=1 and mem_ack=0, the write request and its address and data hold steady and ready=0. Paired stores presented then are not accepted and give no response.
- R11: Priority within one cycle is clear, then paired store, then load-exclusive. A clear presented together with a store makes that store fail. A load-exclusive presented together with an accepted store is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ldx_valid | input | 1 | Load-exclusive: arm the monitor |
| ldx_addr | input | AW | Base of the armed span |
| ldx_log2 | input | LW | log2 of the armed span in bytes |
| clr_valid | input | 1 | Return the monitor to open |
| st_valid | input | 1 | Paired store request |
| st_addr | input | AW | Base address of the pair |
| st_elem_a | input | EW | First element |
| st_elem_b | input | EW | Second element |
| st_wide | input | 1 | 1: full-width elements, 0: half-width elements |
| st_big_endian | input | 1 | 1: big-endian placement |
| st_base_is_sp | input | 1 | Base comes from the stack pointer |
| ready | output | 1 | Paired store may be accepted |
| resp_valid | output | 1 | Status result valid |
| resp_status | output | 32 | 0 stored, 1 not stored |
| align_fault | output | 1 | Store rejected for alignment |
| mem_we | output | 1 | Combined write request |
| mem_addr | output | AW | Write address |
| mem_wide | output | 1 | 1: 16-byte write, 0: 8-byte write |
| mem_wdata | output | 2*EW | Combined write data |
| mem_ack | input | 1 | Memory accepts the write |

## Verification
The assertions check the properties that hold on every cycle. Responses follow accepted requests by exactly one cycle, and status bits 31:1 stay zero. A failed or faulting response never comes with a write, and a passing one always does. The monitor is open whenever a response is visible and after any clear, and a stalled write holds its address and data. Only the bench scenarios can show the values that depend on the operands: the span comparisons at their edges, the placement of the halves for each byte order and element size, the stack-pointer alignment rule, and the same-cycle priority between clear, store and load-exclusive.

// File: rtl/excl_pkg.sv
// Shared types for the exclusive monitor and the paired store unit.
// Assumes: no other package defines these names.
package excl_pkg;
    typedef enum logic {
        MON_OPEN = 1'b0,
        MON_EXCL = 1'b1
    } mon_state_e;
endpackage

// File: rtl/excl_monitor.sv
// Local exclusive monitor. It holds an armed address and a log2 span.
// Assumes: the caller resolves priority, so clear wins over arm when both are asserted.
module excl_monitor #(
    parameter int AW = 64,
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [AW-1:0] arm_addr,
    input  logic [LW-1:0] arm_log2,
    input  logic          clear,
    output logic          armed,
    output logic [AW-1:0] mon_addr,
    output logic [LW-1:0] mon_log2
);
    import excl_pkg::*;

    mon_state_e state_q;

    // State update: clear returns to open, arm records a new span.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= MON_OPEN;
            mon_addr <= '0;
            mon_log2 <= '0;
        end else if (clear) begin
            state_q  <= MON_OPEN;
        end else if (arm) begin
            state_q  <= MON_EXCL;
            mon_addr <= arm_addr;
            mon_log2 <= arm_log2;
        end
    end

    assign armed = (state_q == MON_EXCL);
endmodule

// File: rtl/pair_packer.sv
// Places two elements into one combined write word according to element size and byte order.
// Assumes: EW is even. Half-width elements use the low EW/2 bits of each operand.
module pair_packer #(
    parameter int EW = 64
) (
    input  logic [EW-1:0]   elem_a,
    input  logic [EW-1:0]   elem_b,
    input  logic            wide,
    input  logic            big_endian,
    output logic [2*EW-1:0] packed_data
);
    localparam int HW = EW / 2;

    // Select the half order and zero the unused upper half for narrow pairs.
    always_comb begin
        if (wide) begin
            packed_data = big_endian ? {elem_a, elem_b} : {elem_b, elem_a};
        end else if (big_endian) begin
            packed_data = {{EW{1'b0}}, elem_a[HW-1:0], elem_b[HW-1:0]};
        end else begin
            packed_data = {{EW{1'b0}}, elem_b[HW-1:0], elem_a[HW-1:0]};
        end
    end
endmodule

// File: rtl/excl_pair_store.sv
// Paired conditional store unit. It checks the span and alignment, issues one registered
// write on a pass and returns a zero-extended status.
// Assumes: memory holds mem_ack until it has taken the write, and requests are sampled on the rising edge.
module excl_pair_store #(
    parameter int AW          = 64,
    parameter int EW          = 64,
    parameter int LW          = 3,
    parameter int SP_ALIGN_LG = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ldx_valid,
    input  logic [AW-1:0] ldx_addr,
    input  logic [LW-1:0] ldx_log2,
    input  logic          clr_valid,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [EW-1:0] st_elem_a,
    input  logic [EW-1:0] st_elem_b,
    input  logic          st_wide,
    input  logic          st_big_endian,
    input  logic          st_base_is_sp,
    output logic          ready,
    output logic          resp_valid,
    output logic [31:0]   resp_status,
    output logic          align_fault,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic          mem_wide,
    output logic [2*EW-1:0] mem_wdata,
    input  logic          mem_ack
);
    localparam int XW        = AW + 1;
    localparam int NARROW_B  = EW / 8;
    localparam int WIDE_B    = EW / 4;
    localparam int NARROW_LG = $clog2(NARROW_B);
    localparam int WIDE_LG   = $clog2(WIDE_B);

    logic          st_acc;
    logic          mon_armed;
    logic [AW-1:0] mon_addr;
    logic [LW-1:0] mon_log2;
    logic [2*EW-1:0] pair_data;
    logic [XW-1:0] span_lo, span_hi, tgt_lo, tgt_hi;
    logic          covered, misaligned, sp_misaligned, fault, success;

    assign ready  = !mem_we;
    assign st_acc = st_valid && ready;

    excl_monitor #(.AW(AW), .LW(LW)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (ldx_valid && !clr_valid && !st_acc),
        .arm_addr (ldx_addr),
        .arm_log2 (ldx_log2),
        .clear    (clr_valid || st_acc),
        .armed    (mon_armed),
        .mon_addr (mon_addr),
        .mon_log2 (mon_log2)
    );

    pair_packer #(.EW(EW)) u_pack (
        .elem_a      (st_elem_a),
        .elem_b      (st_elem_b),
        .wide        (st_wide),
        .big_endian  (st_big_endian),
        .packed_data (pair_data)
    );

    // Span coverage test using one extra bit so the end addresses cannot wrap.
    always_comb begin
        span_lo = {1'b0, mon_addr};
        span_hi = span_lo + (XW'(1) << mon_log2);
        tgt_lo  = {1'b0, st_addr};
        tgt_hi  = tgt_lo + (st_wide ? XW'(WIDE_B) : XW'(NARROW_B));
        covered = mon_armed && !clr_valid && (tgt_lo >= span_lo) && (tgt_hi <= span_hi);
    end

    // Alignment test for the total size and for a stack-pointer base.
    always_comb begin
        misaligned    = st_wide ? (|st_addr[WIDE_LG-1:0]) : (|st_addr[NARROW_LG-1:0]);
        sp_misaligned = st_base_is_sp && (|st_addr[SP_ALIGN_LG-1:0]);
        fault         = misaligned || sp_misaligned;
        success       = covered && !fault;
    end

    // Registered response, valid for the single cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_status <= '0;
            align_fault <= 1'b0;
        end else begin
            resp_valid  <= st_acc;
            resp_status <= {31'd0, !(st_acc && success)};
            align_fault <= st_acc && fault;
        end
    end

    // Write request: launched on a pass, held until memory acknowledges it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wide  <= 1'b0;
            mem_wdata <= '0;
        end else if (st_acc && success) begin
            mem_we    <= 1'b1;
            mem_addr  <= st_addr;
            mem_wide  <= st_wide;
            mem_wdata <= pair_data;
        end else if (mem_ack) begin
            mem_we    <= 1'b0;
        end
    end
endmodule

// File: rtl/excl_pair_store_chk.sv
// Property checker for the paired store unit, attached with bind.
// Assumes: it sees the top-level ports and the monitor armed flag.
module excl_pair_store_chk #(
    parameter int AW = 64,
    parameter int EW = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            st_valid,
    input logic            ready,
    input logic            clr_valid,
    input logic            resp_valid,
    input logic [31:0]     resp_status,
    input logic            align_fault,
    input logic            mem_we,
    input logic            mem_ack,
    input logic [AW-1:0]   mem_addr,
    input logic [2*EW-1:0] mem_wdata,
    input logic            mon_armed
);
    p_resp_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && ready) |=> resp_valid);
    p_no_spurious_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_valid && ready) |=> !resp_valid);
    p_status_zext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_status[31:1] == 31'd0));
    p_fail_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_status[0]) |-> !mem_we);
    p_pass_writes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_status[0]) |-> mem_we);
    p_fault_fails_r8: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> (resp_valid && resp_status[0]));
    p_monitor_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !mon_armed);
    p_clear_opens_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid |=> !mon_armed);
    p_hold_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_ack) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata)));
endmodule

bind excl_pair_store excl_pair_store_chk #(.AW(AW), .EW(EW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_valid    (st_valid),
    .ready       (ready),
    .clr_valid   (clr_valid),
    .resp_valid  (resp_valid),
    .resp_status (resp_status),
    .align_fault (align_fault),
    .mem_we      (mem_we),
    .mem_ack     (mem_ack),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mon_armed   (mon_armed)
);

// File: tb/test_excl_pair_store.sv
`timescale 1ns/1ps
// Directed bench for the paired store unit. Each scenario task checks its own results.
module test_excl_pair_store;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ldx_valid = 1'b0;
    logic [63:0]  ldx_addr = '0;
    logic [2:0]   ldx_log2 = '0;
    logic         clr_valid = 1'b0;
    logic         st_valid = 1'b0;
    logic [63:0]  st_addr = '0;
    logic [63:0]  st_elem_a = '0;
    logic [63:0]  st_elem_b = '0;
    logic         st_wide = 1'b0;
    logic         st_big_endian = 1'b0;
    logic         st_base_is_sp = 1'b0;
    logic         ready, resp_valid, align_fault, mem_we, mem_wide;
    logic [31:0]  resp_status;
    logic [63:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic         mem_ack = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    int wr_cnt = 0;

    logic         g_valid, g_fault, g_we, g_wide;
    logic [31:0]  g_status;
    logic [63:0]  g_addr;
    logic [127:0] g_data;

    localparam logic [63:0] EA = 64'h1111_2222_AAAA_0001;
    localparam logic [63:0] EB = 64'h3333_4444_BBBB_0002;

    always #4 clk = ~clk;

    excl_pair_store i_excl_pair_store (
        .clk(clk), .rst_n(rst_n),
        .ldx_valid(ldx_valid), .ldx_addr(ldx_addr), .ldx_log2(ldx_log2),
        .clr_valid(clr_valid),
        .st_valid(st_valid), .st_addr(st_addr), .st_elem_a(st_elem_a), .st_elem_b(st_elem_b),
        .st_wide(st_wide), .st_big_endian(st_big_endian), .st_base_is_sp(st_base_is_sp),
        .ready(ready), .resp_valid(resp_valid), .resp_status(resp_status),
        .align_fault(align_fault), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wide(mem_wide), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
    );

    // Count writes taken by the memory model.
    always @(posedge clk) if (rst_n && mem_we && mem_ack) wr_cnt <= wr_cnt + 1;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic arm(input logic [63:0] a, input logic [2:0] lg);
        ldx_valid = 1'b1; ldx_addr = a; ldx_log2 = lg;
        idle();
        ldx_valid = 1'b0;
    endtask

    task automatic do_st(input logic [63:0] a, input logic wide, input logic big, input logic sp,
                         input logic with_clr, input logic with_ldx);
        st_valid = 1'b1; st_addr = a; st_wide = wide; st_big_endian = big; st_base_is_sp = sp;
        st_elem_a = EA; st_elem_b = EB; clr_valid = with_clr;
        ldx_valid = with_ldx; ldx_addr = a; ldx_log2 = 3'd5;
        @(posedge clk);
        @(negedge clk);
        st_valid = 1'b0; clr_valid = 1'b0; ldx_valid = 1'b0;
        g_valid = resp_valid; g_status = resp_status; g_fault = align_fault;
        g_we = mem_we; g_addr = mem_addr; g_wide = mem_wide; g_data = mem_wdata;
        idle();
    endtask

    task automatic expect_fail(input string req);
        int w0;
        w0 = wr_cnt;
        chk(g_valid == 1'b1, req, 128'(g_valid), 128'd1);
        chk(g_status == 32'd1, req, 128'(g_status), 128'd1);
        chk(g_we == 1'b0 && wr_cnt == w0, {req, " R7"}, 128'(g_we), 128'd0);
    endtask

    task automatic t_reset();
        chk(ready == 1'b1, "R1", 128'(ready), 128'd1);
        chk(resp_valid == 1'b0 && mem_we == 1'b0 && align_fault == 1'b0, "R1",
            128'({resp_valid, mem_we, align_fault}), 128'd0);
        do_st(64'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_fail("R1 open after reset");
    endtask

    task automatic t_pack();
        arm(64'h1000, 3'd4);
        do_st(64'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(g_valid && g_status == 32'd0, "R2 R5 pass", 128'(g_status), 128'd0);
        chk(g_we && g_addr == 64'h1000 && !g_wide, "R4 addr", 128'(g_addr), 128'h1000);
        chk(g_data == {64'd0, 32'hBBBB_0002, 32'hAAAA_0001}, "R4 narrow little", g_data,
            {64'd0, 32'hBBBB_0002, 32'hAAAA_0001});
        do_st(64'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_fail("R6 repeat");
        arm(64'h1000, 3'd4);
        do_st(64'h1000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(g_data == {64'd0, 32'hAAAA_0001, 32'hBBBB_0002}, "R4 narrow big", g_data,
            {64'd0, 32'hAAAA_0001, 32'hBBBB_0002});
        arm(64'h1000, 3'd4);
        do_st(64'h1000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(g_status == 32'd0 && g_wide && g_data == {EA, EB}, "R4 wide big", g_data, {EA, EB});
        arm(64'h1000, 3'd4);
        do_st(64'h1000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(g_status == 32'd0 && g_data == {EB, EA}, "R4 wide little", g_data, {EB, EA});
    endtask

    task automatic t_span();
        arm(64'h1000, 3'd3);
        do_st(64'h1000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_fail("R3 wide exceeds 8-byte span");
        arm(64'h1000, 3'd3);
        do_st(64'h1008, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_fail("R3 beyond span");
        arm(64'h1000, 3'd5);
        do_st(64'h1018, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(g_status == 32'd0 && g_addr == 64'h1018, "R3 top of span", 128'(g_status), 128'd0);
        arm(64'h1010, 3'd4);
        do_st(64'h1008, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_fail("R3 below span");
    endtask

    task automatic t_align();
        arm(64'h2000, 3'd5);
        do_st(64'h2004, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_fail("R8 narrow misaligned");
        chk(g_fault == 1'b1, "R8 fault", 128'(g_fault), 128'd1);
        arm(64'h2000, 3'd5);
        do_st(64'h2008, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_fail("R8 wide misaligned");
        arm(64'h2000, 3'd5);
        do_st(64'h2008, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_fail("R8 sp misaligned");
        chk(g_fault == 1'b1, "R8 sp fault", 128'(g_fault), 128'd1);
        arm(64'h2000, 3'd5);
        do_st(64'h2010, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk(g_status == 32'd0 && g_fault == 1'b0, "R8 sp aligned", 128'(g_status), 128'd0);
    endtask

    task automatic t_clear();
        arm(64'h3000, 3'd4);
        clr_valid = 1'b1;
        idle();
        clr_valid = 1'b0;
        do_st(64'h3000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_fail("R9 clear");
        arm(64'h3000, 3'd4);
        do_st(64'h3000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_fail("R11 clear with store");
        arm(64'h3000, 3'd4);
        do_st(64'h3000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk(g_status == 32'd0, "R11 store with ldx passes", 128'(g_status), 128'd0);
        do_st(64'h3000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_fail("R11 ldx dropped");
    endtask

    task automatic t_backpressure();
        int w0;
        mem_ack = 1'b0;
        arm(64'h4000, 3'd4);
        st_valid = 1'b1; st_addr = 64'h4000; st_wide = 1'b0; st_big_endian = 1'b0; st_base_is_sp = 1'b0;
        @(posedge clk);
        @(negedge clk);
        st_valid = 1'b0;
        w0 = wr_cnt;
        chk(mem_we && !ready, "R10 pending", 128'({mem_we, ready}), 128'b10);
        arm(64'h4000, 3'd4);
        st_valid = 1'b1; st_addr = 64'h4008;
        @(posedge clk);
        @(negedge clk);
        st_valid = 1'b0;
        chk(!resp_valid, "R10 not accepted", 128'(resp_valid), 128'd0);
        chk(mem_we && mem_addr == 64'h4000, "R10 hold", 128'(mem_addr), 128'h4000);
        mem_ack = 1'b1;
        idle();
        chk(!mem_we && ready && wr_cnt == w0 + 1, "R10 release", 128'(wr_cnt - w0), 128'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pack();
        t_span();
        t_align();
        t_clear();
        t_backpressure();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule